// File: doc/BRIEF.md
# Command-Queued SPI Master

This block is an SPI master that works from a small queue of 32-bit push words. Each word pairs a 16-bit command with up to 16 bits of transmit data. The engine takes one word from the queue at a time and shifts the frame out on `sck`/`mosi`. It samples `miso` into a receive queue, and it drives one active-low chip-select line picked by the command. Because every frame carries its own command, software can queue a chain of frames. Those frames can share one chip-select assertion, and a flag marks the end of the batch.

Clock polarity, clock phase, bit order and frame length come from a configuration word, which is sampled as each frame starts. A timing generator outside the block paces the SCK half periods with a one-cycle tick. It also ends each requested delay phase (chip-select-to-clock, after-clock, inter-frame gap) with a one-cycle done pulse. The block reports a per-frame transfer counter and three sticky status flags. Each flag is cleared by writing a 1 to its bit.

Top module: `spiq_master`

## Requirements
- R1: A push word holds the command in bits 31:16 and the data in bits 15:0. The transmit queue holds 4 words, `tx_full` reports a full queue, and a push while full is dropped. Frames leave in push order.
- R2: Command bits 5:0 are a one-hot select, and the matching `cs_n` line is low during the frame. When command bit 15 (hold) is set, that line stays low after the frame, and the next frame starts without a lead delay.
- R3: Without hold, a frame follows this order: lead delay (`dly_req`=1), clocking, after-clock delay (`dly_req`=2), chip-select release, gap delay (`dly_req`=3). Each phase ends on `dly_done`. `attr_sel` carries command bits 14:12 during the frame.
- R4: `count_word[31:16]` rises by one per completed frame. Command bit 10 zeroes it before its frame is sent.
- R5: `stat_word[31]` is set by every completed frame. `stat_word[28]` is set by a frame whose command bit 11 is set. Writing 1 to a bit through `stat_wr`/`stat_wdata` clears it.
- R6: The configuration word carries polarity in bit 26, phase in bit 25, LSB-first in bit 24 and the frame length minus one in bits 30:27 (4 to 16 bits). Phase 0 samples on the leading edge, and phase 1 samples on the trailing edge.
- R7: One received frame enters a 4-entry receive queue for each sent frame. It is zero above the frame length, `rx_word` shows the oldest entry, and `rx_pop` removes it.
- R8: A frame that finds the receive queue full is discarded, and `stat_word[19]` is set.
- R9: `ctrl_wr` with `ctrl_word[11]` empties the transmit queue, and with `ctrl_word[10]` empties the receive queue.
- R10: After reset, all `cs_n` lines are high, status and counter are zero, both queues are empty and no delay is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_wr | input | 1 | Push strobe |
| push_word | input | 32 | Command and data word |
| tx_full | output | 1 | Transmit queue full |
| cfg_word | input | 32 | Frame configuration |
| ctrl_wr | input | 1 | Control strobe |
| ctrl_word | input | 32 | Queue flush bits |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 32 | Write-one-to-clear mask |
| stat_word | output | 32 | Status flags |
| count_word | output | 32 | Transfer counter in upper half |
| rx_pop | input | 1 | Remove oldest received frame |
| rx_word | output | 16 | Oldest received frame |
| rx_empty | output | 1 | Receive queue empty |
| sck_tick | input | 1 | SCK half-period enable |
| dly_req | output | 2 | Delay phase requested (0 none) |
| dly_done | input | 1 | Requested delay phase finished |
| attr_sel | output | 3 | Timing set of current frame |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 6 | Active-low chip selects |

## Verification
The assertions assume `cfg_word` changes only while no frame is in flight, so the idle clock level moves only between frames. They also assume every pushed command selects at most one chip-select line. The stimulus respects both assumptions. It changes the configuration only after all queued frames have finished, and it builds each select field as a single shifted bit. The timing generator is modelled in the bench as a free-running alternate-cycle tick and a done pulse that answers each delay request after one cycle. `miso` is looped back from `mosi`, so the receive data can be predicted.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  // configuration word fields
  localparam int CFG_CPOL   = 26;
  localparam int CFG_CPHA   = 25;
  localparam int CFG_LSB    = 24;
  localparam int CFG_FSZ_LO = 27;
  localparam int CFG_FSZ_W  = 4;
  // control strobes
  localparam int CTRL_FLUSH_TX = 11;
  localparam int CTRL_FLUSH_RX = 10;
  // status bits
  localparam int ST_TCF = 31;
  localparam int ST_EOQ = 28;
  localparam int ST_OVF = 19;
  localparam int CS_LINES = 6;

  typedef struct packed {
    logic                hold;
    logic [2:0]          attr;
    logic                last;
    logic                zero_cnt;
    logic [3:0]          spare;
    logic [CS_LINES-1:0] sel;
  } spiq_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_ARM, ST_SHIFT, ST_TRAIL, ST_GAP
  } spiq_state_t;

  localparam logic [1:0] DLY_NONE  = 2'd0;
  localparam logic [1:0] DLY_LEAD  = 2'd1;
  localparam logic [1:0] DLY_TRAIL = 2'd2;
  localparam logic [1:0] DLY_GAP   = 2'd3;
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign full  = (cnt_q == LW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign level = cnt_q;
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rp_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= bump(wp_q);
      if (do_rd) rp_q <= bump(rp_q);
      if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
      else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/spiq_shift.sv
module spiq_shift #(
  parameter int MAXB = 16,
  localparam int CW  = $clog2(MAXB + 1),
  localparam int EW  = $clog2(2 * MAXB),
  localparam int IW  = $clog2(MAXB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            tick,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            lsb_first,
  input  logic [CW-1:0]   nbits,
  input  logic [MAXB-1:0] txd,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            done,
  output logic [MAXB-1:0] rxd
);
  logic            run_q, pha_q, lsb_q, sck_q, done_q;
  logic [EW-1:0]   ecnt_q;
  logic [CW-1:0]   nb_q;
  logic [MAXB-1:0] txd_q, rxd_q;
  logic [EW-1:0]   out_idx, smp_idx;
  logic            last_edge, smp_edge;

  // position of logical bit i inside the data word
  function automatic logic [IW-1:0] bitpos(input logic l, input logic [CW-1:0] n,
                                           input logic [EW-1:0] i);
    return l ? IW'(i) : IW'(n - 1'b1) - IW'(i);
  endfunction

  assign out_idx   = pha_q ? ((ecnt_q == '0) ? '0 : (ecnt_q - 1'b1) >> 1) : ecnt_q >> 1;
  assign smp_idx   = ecnt_q >> 1;
  assign last_edge = (ecnt_q == EW'({nb_q, 1'b0} - 1'b1));
  assign smp_edge  = (ecnt_q[0] == pha_q);

  assign mosi = txd_q[bitpos(lsb_q, nb_q, out_idx)];
  assign sck  = sck_q;
  assign done = done_q;
  assign rxd  = rxd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pha_q  <= 1'b0;
      lsb_q  <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      ecnt_q <= '0;
      nb_q   <= '0;
      txd_q  <= '0;
      rxd_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        run_q  <= 1'b1;
        ecnt_q <= '0;
        pha_q  <= cpha;
        lsb_q  <= lsb_first;
        nb_q   <= nbits;
        txd_q  <= txd;
        rxd_q  <= '0;
        sck_q  <= cpol;
      end else if (run_q) begin
        if (tick) begin
          sck_q <= ~sck_q;
          if (smp_edge) rxd_q[bitpos(lsb_q, nb_q, smp_idx)] <= miso;
          if (last_edge) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            ecnt_q <= ecnt_q + 1'b1;
          end
        end
      end else begin
        sck_q <= cpol;
      end
    end
  end
endmodule

// File: rtl/spiq_master.sv
module spiq_master
  import spiq_pkg::*;
#(
  parameter int TXQ_DEPTH = 4,
  parameter int RXQ_DEPTH = 4,
  parameter int MAXB      = 16,
  localparam int CNTW     = 16,
  localparam int CW       = $clog2(MAXB + 1),
  localparam int TLW      = $clog2(TXQ_DEPTH + 1),
  localparam int RLW      = $clog2(RXQ_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_wr,
  input  logic [31:0]         push_word,
  output logic                tx_full,
  input  logic [31:0]         cfg_word,
  input  logic                ctrl_wr,
  input  logic [31:0]         ctrl_word,
  input  logic                stat_wr,
  input  logic [31:0]         stat_wdata,
  output logic [31:0]         stat_word,
  output logic [31:0]         count_word,
  input  logic                rx_pop,
  output logic [MAXB-1:0]     rx_word,
  output logic                rx_empty,
  input  logic                sck_tick,
  output logic [1:0]          dly_req,
  input  logic                dly_done,
  output logic [2:0]          attr_sel,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic [CS_LINES-1:0] cs_n
);
  spiq_state_t         st_q, st_d;
  spiq_cmd_t           cmd_q, head_cmd;
  logic [MAXB-1:0]     dat_q, rx_frame;
  logic [31:0]         head;
  logic [CNTW-1:0]     cnt_q;
  logic [CS_LINES-1:0] cs_act_q;
  logic                hold_q, tcf_q, eoq_q, ovf_q;
  logic                tx_empty, rx_full, sh_done;
  logic                pop_tx, load, start, fin, rel;
  logic [TLW-1:0]      txq_level;
  logic [RLW-1:0]      rxq_level_unused;
  logic                flush_tx, flush_rx;
  logic                spiq_unused;

  assign flush_tx = ctrl_wr && ctrl_word[CTRL_FLUSH_TX];
  assign flush_rx = ctrl_wr && ctrl_word[CTRL_FLUSH_RX];
  assign head_cmd = spiq_cmd_t'(head[31:16]);

  spiq_fifo #(.W(32), .DEPTH(TXQ_DEPTH)) txq_i (
    .clk(clk), .rst_n(rst_n), .flush(flush_tx), .wr(push_wr), .wdata(push_word),
    .rd(pop_tx), .rdata(head), .full(tx_full), .empty(tx_empty), .level(txq_level));

  spiq_fifo #(.W(MAXB), .DEPTH(RXQ_DEPTH)) rxq_i (
    .clk(clk), .rst_n(rst_n), .flush(flush_rx), .wr(fin), .wdata(rx_frame),
    .rd(rx_pop), .rdata(rx_word), .full(rx_full), .empty(rx_empty), .level(rxq_level_unused));

  spiq_shift #(.MAXB(MAXB)) shift_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(sck_tick),
    .cpol(cfg_word[CFG_CPOL]), .cpha(cfg_word[CFG_CPHA]), .lsb_first(cfg_word[CFG_LSB]),
    .nbits(CW'(cfg_word[CFG_FSZ_LO +: CFG_FSZ_W]) + 1'b1), .txd(dat_q), .miso(miso),
    .sck(sck), .mosi(mosi), .done(sh_done), .rxd(rx_frame));

  // next-state logic
  always_comb begin
    st_d   = st_q;
    pop_tx = 1'b0;
    load   = 1'b0;
    start  = 1'b0;
    fin    = 1'b0;
    rel    = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (!tx_empty) begin
                  pop_tx = 1'b1;
                  load   = 1'b1;
                  st_d   = hold_q ? ST_ARM : ST_LEAD;
                end
      ST_LEAD:  if (dly_done) begin
                  start = 1'b1;
                  st_d  = ST_SHIFT;
                end
      ST_ARM:   begin
                  start = 1'b1;
                  st_d  = ST_SHIFT;
                end
      ST_SHIFT: if (sh_done) begin
                  fin  = 1'b1;
                  st_d = cmd_q.hold ? ST_IDLE : ST_TRAIL;
                end
      ST_TRAIL: if (dly_done) begin
                  rel  = 1'b1;
                  st_d = ST_GAP;
                end
      ST_GAP:   if (dly_done) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cmd_q    <= '0;
      dat_q    <= '0;
      hold_q   <= 1'b0;
      cs_act_q <= '0;
      cnt_q    <= '0;
      tcf_q    <= 1'b0;
      eoq_q    <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load) begin
        cmd_q    <= head_cmd;
        dat_q    <= head[MAXB-1:0];
        cs_act_q <= head_cmd.sel;
      end else if (rel) begin
        cs_act_q <= '0;
      end
      if (fin) hold_q <= cmd_q.hold;
      if (load && head_cmd.zero_cnt) cnt_q <= '0;
      else if (fin)                  cnt_q <= cnt_q + 1'b1;
      if (fin)                               tcf_q <= 1'b1;
      else if (stat_wr && stat_wdata[ST_TCF]) tcf_q <= 1'b0;
      if (fin && cmd_q.last)                 eoq_q <= 1'b1;
      else if (stat_wr && stat_wdata[ST_EOQ]) eoq_q <= 1'b0;
      if (fin && rx_full)                    ovf_q <= 1'b1;
      else if (stat_wr && stat_wdata[ST_OVF]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    stat_word         = '0;
    stat_word[ST_TCF] = tcf_q;
    stat_word[ST_EOQ] = eoq_q;
    stat_word[ST_OVF] = ovf_q;
  end

  assign count_word = {cnt_q, 16'h0000};
  assign cs_n       = ~cs_act_q;
  assign attr_sel   = cmd_q.attr;
  assign dly_req    = (st_q == ST_LEAD)  ? DLY_LEAD  :
                      (st_q == ST_TRAIL) ? DLY_TRAIL :
                      (st_q == ST_GAP)   ? DLY_GAP   : DLY_NONE;

  assign spiq_unused = ^{cfg_word[31], cfg_word[23:0], ctrl_word[31:12], ctrl_word[9:0],
                         stat_wdata[30:29], stat_wdata[27:20], stat_wdata[18:0],
                         cmd_q.spare, head[31 -: 1] & 1'b0};
endmodule

// File: rtl/spiq_chk.sv
module spiq_chk #(
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [5:0]    cs_n,
  input logic          sck,
  input logic [1:0]    dly_req,
  input logic          tcf,
  input logic          eoq,
  input logic [15:0]   cnt,
  input logic [LW-1:0] txq_level
);
  // R1
  txq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txq_level <= LW'(DEPTH));

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R3
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_n == 6'h3f) && ($past(cs_n) != 6'h3f)) |-> ($past(dly_req) == 2'd2));

  // R3
  sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dly_req != 2'd0) && ($past(dly_req) != 2'd0)) |-> $stable(sck));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + 16'd1) || (cnt == 16'd0)));

  // R5
  eoq_with_tcf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoq) |-> tcf);
endmodule

bind spiq_master spiq_chk #(.DEPTH(TXQ_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .dly_req(dly_req),
  .tcf(stat_word[31]), .eoq(stat_word[28]), .cnt(count_word[31:16]),
  .txq_level(txq_level));

// File: tb/spiq_master_tb_top.sv
module spiq_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_wr, ctrl_wr, stat_wr, rx_pop, sck_tick, dly_done;
  logic [31:0] push_word, cfg_word, ctrl_word, stat_wdata, stat_word, count_word;
  logic        tx_full, rx_empty, sck, mosi;
  logic [15:0] rx_word;
  logic [1:0]  dly_req;
  logic [2:0]  attr_sel;
  logic [5:0]  cs_n;

  int vecs = 0, errs = 0;
  logic tick_en = 1'b0, resp_en = 1'b0, mon_on = 1'b0, hist_clr = 1'b0;
  logic cur_cpol = 1'b0, cur_cpha = 1'b0, cur_lsb = 1'b0;
  int   cur_nb = 8;
  int   exp_cnt = 0;

  always #10 clk = ~clk;

  spiq_master dut_i (
    .clk(clk), .rst_n(rst_n), .push_wr(push_wr), .push_word(push_word), .tx_full(tx_full),
    .cfg_word(cfg_word), .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .stat_word(stat_word), .count_word(count_word),
    .rx_pop(rx_pop), .rx_word(rx_word), .rx_empty(rx_empty), .sck_tick(sck_tick),
    .dly_req(dly_req), .dly_done(dly_done), .attr_sel(attr_sel), .sck(sck),
    .mosi(mosi), .miso(mosi), .cs_n(cs_n));

  // timing generator model
  always @(posedge clk) begin
    sck_tick <= tick_en & ~sck_tick;
    dly_done <= resp_en && (dly_req != 2'd0) && !dly_done;
  end

  // delay-phase history
  logic [15:0] hist;
  logic [1:0]  prev_req;
  always @(posedge clk) begin
    if (hist_clr) hist <= '0;
    else if (dly_req != 2'd0 && dly_req != prev_req) hist <= {hist[13:0], dly_req};
    prev_req <= dly_req;
  end

  // serial monitor
  int          mbits = 0, mon_n = 0;
  logic [15:0] mw;
  logic [15:0] mon_d [0:255];
  logic [5:0]  mon_cs [0:255];
  logic [2:0]  mon_at [0:255];
  always @(posedge sck or negedge sck) begin
    if (mon_on && (sck == (~cur_cpol ^ cur_cpha))) begin
      if (mbits == 0) mw = '0;
      if (cur_lsb) mw[mbits[3:0]] = mosi;
      else         mw = {mw[14:0], mosi};
      mbits = mbits + 1;
      if (mbits == cur_nb) begin
        mon_d[mon_n]  = mw;
        mon_cs[mon_n] = cs_n;
        mon_at[mon_n] = attr_sel;
        mon_n = mon_n + 1;
        mbits = 0;
      end
    end
  end

  function automatic logic [15:0] msk(input int nb);
    logic [16:0] m;
    m = (17'h1 << nb) - 17'h1;
    return m[15:0];
  endfunction

  function automatic logic [31:0] mkword(input logic hold, input logic [2:0] at, input logic last,
                                         input logic zc, input logic [5:0] sel, input logic [15:0] d);
    return {hold, at, last, zc, 4'h0, sel, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); push_wr = 1'b1; push_word = w;
    @(negedge clk); push_wr = 1'b0;
  endtask

  task automatic set_cfg(input int nb, input logic pol, input logic pha, input logic lsb);
    mon_on = 1'b0;
    @(negedge clk);
    cfg_word = {1'b0, 4'(nb - 1), pol, pha, lsb, 24'h0};
    cur_nb = nb; cur_cpol = pol; cur_cpha = pha; cur_lsb = lsb;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;
  endtask

  task automatic wait_frames(input int target);
    while (mon_n < target) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic pop_chk(input logic [15:0] exp, input string req);
    @(negedge clk);
    chk(!rx_empty && rx_word == exp, req, {15'h0, rx_empty, rx_word}, {16'h0, exp});
    rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk); stat_wr = 1'b1; stat_wdata = 32'h9008_0000;
    @(negedge clk); stat_wr = 1'b0;
  endtask

  task automatic run_batch(input int fixed_nb);
    int nb, k, base;
    logic zc;
    logic [15:0] d [4];
    logic [5:0]  s [4];
    logic [2:0]  a [4];
    nb = (fixed_nb != 0) ? fixed_nb : 4 + int'($urandom % 13);
    set_cfg(nb, 1'($urandom), 1'($urandom), 1'($urandom));
    k = 1 + int'($urandom % 4);
    base = mon_n;
    zc = 1'($urandom);
    for (int i = 0; i < k; i++) begin
      d[i] = 16'($urandom);
      s[i] = 6'(1 << ($urandom % 6));
      a[i] = 3'($urandom);
      push(mkword((i < k - 1) ? 1'($urandom) : 1'b0, a[i], i == k - 1, zc && i == 0, s[i], d[i]));
    end
    wait_frames(base + k);
    exp_cnt = zc ? k : exp_cnt + k;
    for (int i = 0; i < k; i++) begin
      chk(mon_d[base + i] == (d[i] & msk(nb)), "R6 serial bits", {16'h0, mon_d[base + i]}, {16'h0, d[i] & msk(nb)});
      chk(mon_cs[base + i] == ~s[i], "R2 select", {26'h0, mon_cs[base + i]}, {26'h0, ~s[i]});
      chk(mon_at[base + i] == a[i], "R3 attr_sel", {29'h0, mon_at[base + i]}, {29'h0, a[i]});
    end
    chk(count_word == {16'(exp_cnt), 16'h0}, "R4 counter", count_word, {16'(exp_cnt), 16'h0});
    chk(stat_word == 32'h9000_0000, "R5 flags set", stat_word, 32'h9000_0000);
    chk(cs_n == 6'h3f, "R3 released", {26'h0, cs_n}, 32'h3f);
    for (int i = 0; i < k; i++) pop_chk(d[i] & msk(nb), "R7 rx data");
    chk(rx_empty == 1'b1, "R7 rx drained", {31'h0, rx_empty}, 32'h1);
    clr_flags();
    chk(stat_word == 32'h0, "R5 w1c", stat_word, 32'h0);
  endtask

  task automatic main();
    int base;
    push_wr = 0; ctrl_wr = 0; stat_wr = 0; rx_pop = 0;
    push_word = 0; ctrl_word = 0; stat_wdata = 0;
    cfg_word = {1'b0, 4'd7, 3'b000, 24'h0};
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(cs_n == 6'h3f, "R10 cs_n", {26'h0, cs_n}, 32'h3f);
    chk(stat_word == 0 && count_word == 0, "R10 status/count", stat_word | count_word, 32'h0);
    chk(rx_empty && !tx_full && dly_req == 0, "R10 queues/dly", {29'h0, rx_empty, tx_full, |dly_req}, 32'h4);

    // R3 phase order, R2 hold
    tick_en = 1; resp_en = 1;
    set_cfg(8, 0, 0, 0);
    @(negedge clk); hist_clr = 1; @(negedge clk); hist_clr = 0;
    base = mon_n;
    push(mkword(0, 3'd5, 0, 0, 6'b000100, 16'h00A5));
    wait_frames(base + 1);
    chk(cs_n == 6'h3f, "R3 release after frame", {26'h0, cs_n}, 32'h3f);
    push(mkword(1, 3'd2, 0, 0, 6'b010000, 16'h003C));
    wait_frames(base + 2);
    chk(cs_n == 6'b101111, "R2 hold keeps select", {26'h0, cs_n}, 32'h2f);
    push(mkword(0, 3'd2, 0, 0, 6'b010000, 16'h00C3));
    wait_frames(base + 3);
    chk(hist == 16'h06DB, "R3 delay order", {16'h0, hist}, 32'h06DB);
    chk(mon_d[base + 2] == 16'h00C3, "R1 data order", {16'h0, mon_d[base + 2]}, 32'hC3);
    exp_cnt = 3;
    chk(count_word[31:16] == 16'd3, "R4 accumulate", count_word, 32'h0003_0000);
    chk(stat_word[28] == 1'b0, "R5 no end marker", stat_word, 32'h8000_0000);
    pop_chk(16'h00A5, "R7 first"); pop_chk(16'h003C, "R7 second"); pop_chk(16'h00C3, "R7 third");
    clr_flags();

    // R1 full queue, R8 overflow
    tick_en = 0; resp_en = 0;
    base = mon_n;
    push(mkword(0, 0, 0, 1, 6'b000001, 16'h0011));
    repeat (3) @(negedge clk);
    push(mkword(0, 0, 0, 0, 6'b000010, 16'h0022));
    push(mkword(0, 0, 0, 0, 6'b000010, 16'h0033));
    push(mkword(0, 0, 0, 0, 6'b000010, 16'h0044));
    push(mkword(0, 0, 0, 0, 6'b000010, 16'h0055));
    chk(tx_full == 1'b1, "R1 full at 4", {31'h0, tx_full}, 32'h1);
    push(mkword(0, 0, 0, 0, 6'b000010, 16'h0066));
    tick_en = 1; resp_en = 1;
    wait_frames(base + 5);
    repeat (200) @(negedge clk);
    chk(mon_n == base + 5, "R1 push while full dropped", 32'(mon_n - base), 32'd5);
    chk(mon_d[base + 4] == 16'h0055, "R1 fifth frame", {16'h0, mon_d[base + 4]}, 32'h55);
    chk(stat_word == 32'h8008_0000, "R8 overflow flag", stat_word, 32'h8008_0000);
    chk(count_word[31:16] == 16'd5, "R4 clear then count", count_word, 32'h0005_0000);
    exp_cnt = 5;
    pop_chk(16'h0011, "R8 kept"); pop_chk(16'h0022, "R8 kept");
    pop_chk(16'h0033, "R8 kept"); pop_chk(16'h0044, "R8 kept");
    chk(rx_empty == 1'b1, "R8 late frame dropped", {31'h0, rx_empty}, 32'h1);
    clr_flags();

    // R9 flushes
    tick_en = 0; resp_en = 0;
    base = mon_n;
    push(mkword(0, 0, 1, 0, 6'b100000, 16'h0077));
    repeat (3) @(negedge clk);
    push(mkword(0, 0, 0, 0, 6'b100000, 16'h0088));
    push(mkword(0, 0, 0, 0, 6'b100000, 16'h0099));
    @(negedge clk); ctrl_wr = 1; ctrl_word = 32'h0000_0800;
    @(negedge clk); ctrl_wr = 0;
    tick_en = 1; resp_en = 1;
    wait_frames(base + 1);
    repeat (200) @(negedge clk);
    chk(mon_n == base + 1, "R9 tx flush", 32'(mon_n - base), 32'd1);
    chk(stat_word == 32'h9000_0000, "R5 end marker", stat_word, 32'h9000_0000);
    exp_cnt = 6;
    chk(rx_empty == 1'b0, "R9 rx before flush", {31'h0, rx_empty}, 32'h0);
    @(negedge clk); ctrl_wr = 1; ctrl_word = 32'h0000_0400;
    @(negedge clk); ctrl_wr = 0;
    chk(rx_empty == 1'b1, "R9 rx flush", {31'h0, rx_empty}, 32'h1);
    clr_flags();

    // frame length limits, then random batches
    run_batch(4);
    run_batch(16);
    for (int b = 0; b < 25; b++) run_batch(0);
  endtask

  initial begin
    logic wd;
    void'($urandom(32'h5EED_0042));
    wd = 1'b0;
    fork
      main();
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      vecs++; errs++;
      $display("FAIL watchdog actual=expired expected=finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule